// File: doc/BRIEF.md
# Auxiliary Trigger Timestamp Snapshot Queue

This block watches four asynchronous trigger lines. When any of them goes from low to high, it takes one copy of the free-running system time that is presented to it. Each copy is stored in a first-in first-out queue of sixteen entries, together with a mask of the trigger lines that rose in that same clock.

Software sees the oldest entry at the head outputs. It sees the number of stored entries and a sticky flag that reports a capture that was lost. It removes the head entry with a one-cycle pop strobe. A clear input empties the whole queue and lowers the lost-capture flag.

The time counter, any bus fabric and interrupt routing are outside the block.

Top module: `aux_ts_snapshot`

## Requirements
- R1: `stat_count` reports the number of stored snapshots, from 0 to 16, as a 5-bit value. The value 16 means the queue is full.
- R2: When `fifo_clear` is high at a clock edge, `stat_count` reads 0 and `stat_missed` reads 0 after that edge. A capture or pop in the same cycle has no effect.
- R3: A capture that arrives while the queue holds 16 entries, with no pop in the same cycle, sets `stat_missed`. The new timestamp is discarded, and the count and head entry stay as they were.
- R4: Bit i of `head_mask` stands for trigger input i (bit 0 is trigger 0, bit 3 is trigger 3). A trigger that is high at edge k gives a capture at edge k+2. That capture stores the `sys_time` value present at edge k+2.
- R5: Triggers that rise in the same synchronized cycle produce exactly one entry, with all of their bits set in its mask.
- R6: Each low-to-high transition of a trigger produces exactly one capture. Holding a trigger high adds no further entries.
- R7: After reset, `stat_count`, `stat_missed`, `head_mask` and `head_time` are all 0.
- R8: A pop strobe on a non-empty queue lowers `stat_count` by one. The head outputs then move to the next older entry, so entries leave in capture order.
- R9: A capture and a pop in the same cycle leave `stat_count` unchanged. When the queue is full in that cycle, `stat_missed` is not set.
- R10: `stat_missed` stays high once set, until a clear.
- R11: A pop on an empty queue is ignored, and `stat_count` stays 0. While the queue is empty, `head_mask` and `head_time` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| sys_time | input | 64 | Current system time to be captured |
| trig_in | input | 4 | Asynchronous auxiliary trigger lines |
| pop_strobe | input | 1 | One-cycle request to remove the head entry |
| fifo_clear | input | 1 | Empties the queue and clears the lost-capture flag |
| stat_count | output | 5 | Number of stored snapshots |
| stat_missed | output | 1 | Sticky lost-capture flag |
| head_mask | output | 4 | Trigger mask of the head entry |
| head_time | output | 64 | Timestamp of the head entry |

## Verification
The hardest case to reach is a pop that lands in exactly the cycle in which a synchronized edge is captured while the queue is full. It sits two register stages behind the trigger pins. The stimulus fills the queue with spaced pulses and then raises a trigger. It places the pop strobe two cycles after that trigger, so that both events meet at the same edge. Random phases that favour either captures or pops also bring the queue repeatedly to the full and empty boundaries, and a lock-step model checks every cycle.

// File: rtl/aux_snap_pkg.sv
package aux_snap_pkg;

  // Occupancy after one cycle of optional write and optional read.
  function automatic int unsigned occ_next(int unsigned occ, bit wr, bit rd);
    int unsigned r;
    r = occ;
    if (wr && !rd) r = occ + 1;
    else if (rd && !wr) r = occ - 1;
    return r;
  endfunction

  // Circular pointer advance for a queue of any depth.
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // True when more than one trigger rose together.
  function automatic bit multi_hit(logic [31:0] v);
    return $countones(v) > 1;
  endfunction

endpackage

// File: rtl/aux_trig_sync.sv
module aux_trig_sync #(
  parameter int NTRIG = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTRIG-1:0] trig_in,
  output logic [NTRIG-1:0] rise_o
);

  logic [NTRIG-1:0] meta_q;
  logic [NTRIG-1:0] sync_q;
  logic [NTRIG-1:0] last_q;

  for (genvar i = 0; i < NTRIG; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        last_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= trig_in[i];
        sync_q[i] <= meta_q[i];
        last_q[i] <= sync_q[i];
      end
    end

    assign rise_o[i] = sync_q[i] & ~last_q[i];

    AST_SINGLE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[i] |=> !rise_o[i]);  // R6
  end

endmodule

// File: rtl/aux_snap_fifo.sv
module aux_snap_fifo
  import aux_snap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NTRIG = 4,
  parameter int TS_W  = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int EW    = NTRIG + TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [NTRIG-1:0] push_mask,
  input  logic [TS_W-1:0]  push_time,
  input  logic             pop_req,
  input  logic             clear,
  output logic [CNT_W-1:0] count_o,
  output logic [NTRIG-1:0] head_mask_o,
  output logic [TS_W-1:0]  head_time_o,
  output logic             drop_o
);

  logic [EW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] count_q;
  logic             full_w, empty_w, wr_ok_w, rd_ok_w;
  logic [EW-1:0]    head_w;

  assign full_w  = (count_q == CNT_W'(DEPTH));
  assign empty_w = (count_q == '0);
  assign rd_ok_w = pop_req && !empty_w && !clear;
  assign wr_ok_w = push_req && !clear && (!full_w || rd_ok_w);
  assign drop_o  = push_req && !clear && full_w && !rd_ok_w;

  always_ff @(posedge clk) begin
    if (wr_ok_w) mem[wr_ptr_q] <= {push_mask, push_time};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else if (clear) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_ok_w) wr_ptr_q <= AW'(ptr_next(int'(wr_ptr_q), DEPTH));
      if (rd_ok_w) rd_ptr_q <= AW'(ptr_next(int'(rd_ptr_q), DEPTH));
      count_q <= CNT_W'(occ_next(int'(count_q), wr_ok_w, rd_ok_w));
    end
  end

  assign head_w      = empty_w ? '0 : mem[rd_ptr_q];
  assign head_mask_o = head_w[EW-1:TS_W];
  assign head_time_o = head_w[TS_W-1:0];
  assign count_o     = count_q;

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));  // R1
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count_q == '0);  // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> count_q == CNT_W'(DEPTH) && $stable(rd_ptr_q));  // R3
  AST_PUSH_POP_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !empty_w && !clear) |=> $stable(count_q));  // R9
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_w && pop_req && !push_req) |=> count_q == '0);  // R11
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty_w && !clear) |=> count_q == $past(count_q) - 1'b1);  // R8

endmodule

// File: rtl/aux_snap_status.sv
module aux_snap_status (
  input  logic clk,
  input  logic rst_n,
  input  logic drop_evt,
  input  logic clear,
  output logic missed_o
);

  logic missed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        missed_q <= 1'b0;
    else if (clear)    missed_q <= 1'b0;
    else if (drop_evt) missed_q <= 1'b1;
  end

  assign missed_o = missed_q;

  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> missed_q);  // R3
  AST_MISSED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (missed_q && !clear) |=> missed_q);  // R10
  AST_CLEAR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !missed_q);  // R2

endmodule

// File: rtl/aux_ts_snapshot.sv
module aux_ts_snapshot
  import aux_snap_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NTRIG = 4,
  parameter int TS_W  = 64,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TS_W-1:0]  sys_time,
  input  logic [NTRIG-1:0] trig_in,
  input  logic             pop_strobe,
  input  logic             fifo_clear,
  output logic [CNT_W-1:0] stat_count,
  output logic             stat_missed,
  output logic [NTRIG-1:0] head_mask,
  output logic [TS_W-1:0]  head_time
);

  logic [NTRIG-1:0] rise_w;
  logic             capture_w;
  logic             drop_w;

  aux_trig_sync #(.NTRIG(NTRIG)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig_in (trig_in),
    .rise_o  (rise_w)
  );

  assign capture_w = |rise_w;

  aux_snap_fifo #(.DEPTH(DEPTH), .NTRIG(NTRIG), .TS_W(TS_W)) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_req    (capture_w),
    .push_mask   (rise_w),
    .push_time   (sys_time),
    .pop_req     (pop_strobe),
    .clear       (fifo_clear),
    .count_o     (stat_count),
    .head_mask_o (head_mask),
    .head_time_o (head_time),
    .drop_o      (drop_w)
  );

  aux_snap_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .drop_evt (drop_w),
    .clear    (fifo_clear),
    .missed_o (stat_missed)
  );

  AST_HEAD_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
    stat_count == '0 |-> head_mask == '0 && head_time == '0);  // R11
  AST_MULTI_ONE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_hit(32'(rise_w)) && stat_count == '0 && !fifo_clear)
      |=> stat_count == CNT_W'(1) && head_mask == $past(rise_w));  // R5
  AST_NO_LOSS_ON_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_w && pop_strobe && stat_count == CNT_W'(DEPTH) && !stat_missed && !fifo_clear)
      |=> !stat_missed);  // R9

endmodule

// File: tb/test_aux_ts_snapshot.sv
`timescale 1ns/1ps
module test_aux_ts_snapshot;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys_time = '0;
  logic [3:0]  trig_in = '0;
  logic        pop_strobe = 1'b0;
  logic        fifo_clear = 1'b0;
  logic [4:0]  stat_count;
  logic        stat_missed;
  logic [3:0]  head_mask;
  logic [63:0] head_time;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  aux_ts_snapshot i_aux_ts_snapshot (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time), .trig_in(trig_in),
    .pop_strobe(pop_strobe), .fifo_clear(fifo_clear), .stat_count(stat_count),
    .stat_missed(stat_missed), .head_mask(head_mask), .head_time(head_time)
  );

  // Reference model built from the requirements.
  logic [3:0]  m_s1, m_s2, m_s3;
  logic [3:0]  q_mask [$];
  logic [63:0] q_time [$];
  bit          m_missed;

  function automatic logic [3:0] edges(logic [3:0] cur, logic [3:0] prev);
    return cur & ~prev;
  endfunction

  always @(posedge clk) begin
    logic [3:0] r;
    bit do_pop;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_missed = 0;
      q_mask.delete(); q_time.delete();
    end else begin
      r = edges(m_s2, m_s3);
      do_pop = pop_strobe && q_mask.size() > 0;
      if (fifo_clear) begin
        q_mask.delete(); q_time.delete(); m_missed = 0;
      end else begin
        if (r != 0 && q_mask.size() == DEPTH && !do_pop) m_missed = 1;
        else if (r != 0) begin
          if (do_pop) begin void'(q_mask.pop_front()); void'(q_time.pop_front()); end
          q_mask.push_back(r); q_time.push_back(sys_time);
        end else if (do_pop) begin
          void'(q_mask.pop_front()); void'(q_time.pop_front());
        end
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = trig_in;
    end
  end

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h exp=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_model();
    check("R1 count", 64'(stat_count), 64'(q_mask.size()));
    check("R10 missed", 64'(stat_missed), 64'(m_missed));
    check("R4 mask", 64'(head_mask), q_mask.size() ? 64'(q_mask[0]) : 64'd0);
    check("R8 time", head_time, q_time.size() ? q_time[0] : 64'd0);
  endtask

  // One cycle: compare outputs, then drive the next inputs.
  task automatic cyc(logic [3:0] t, bit p, bit c);
    @(negedge clk);
    compare_model();
    trig_in = t; pop_strobe = p; fifo_clear = c;
    sys_time = {$urandom(), $urandom()};
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(4'h0, 0, 0);
  endtask

  task automatic pulse(logic [3:0] m);
    cyc(m, 0, 0);
    cyc(4'h0, 0, 0);
  endtask

  initial begin
    logic [63:0] t_first;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R7 count", 64'(stat_count), 0);
    check("R7 missed", 64'(stat_missed), 0);
    check("R7 mask", 64'(head_mask), 0);
    check("R7 time", head_time, 0);
    rst_n = 1'b1;

    // Single trigger, latency and mask position.
    pulse(4'h1); idle(3);
    check("R4 one capture", 64'(stat_count), 1);
    check("R4 bit0", 64'(head_mask), 64'h1);

    // Held trigger gives one capture only.
    cyc(4'h8, 0, 0);
    for (int i = 0; i < 10; i++) cyc(4'h8, 0, 0);
    cyc(4'h0, 0, 0); idle(3);
    check("R6 held", 64'(stat_count), 2);

    // Simultaneous triggers.
    pulse(4'hF); idle(3);
    check("R5 count", 64'(stat_count), 3);

    // Pops in order.
    cyc(4'h0, 1, 0); cyc(4'h0, 0, 0);
    check("R8 pop one", 64'(stat_count), 2);
    check("R8 order", 64'(head_mask), 64'h8);
    cyc(4'h0, 1, 0); cyc(4'h0, 0, 0);
    check("R5 mask", 64'(head_mask), 64'hF);
    cyc(4'h0, 1, 0); cyc(4'h0, 0, 0);
    cyc(4'h0, 1, 0); cyc(4'h0, 0, 0);
    check("R11 empty pop", 64'(stat_count), 0);
    check("R11 head zero", 64'(head_mask) | head_time, 0);

    // Fill to full, then overflow.
    for (int i = 0; i < DEPTH; i++) pulse(4'(1 << (i % 4)));
    idle(3);
    check("R1 full", 64'(stat_count), 16);
    t_first = head_time;
    pulse(4'h2); idle(3);
    check("R3 missed set", 64'(stat_missed), 1);
    check("R3 count kept", 64'(stat_count), 16);
    check("R3 head kept", head_time, t_first);
    idle(5);
    check("R10 sticky", 64'(stat_missed), 1);

    // Clear, with a capture landing in the same cycle.
    cyc(4'h4, 0, 0); cyc(4'h0, 0, 0); cyc(4'h0, 0, 1); cyc(4'h0, 0, 0);
    check("R2 count", 64'(stat_count), 0);
    check("R2 missed", 64'(stat_missed), 0);

    // Full queue, capture and pop meet in one cycle.
    for (int i = 0; i < DEPTH; i++) pulse(4'h1);
    idle(3);
    cyc(4'h2, 0, 0); cyc(4'h0, 0, 0); cyc(4'h0, 1, 0); cyc(4'h0, 0, 0);
    check("R9 count", 64'(stat_count), 16);
    check("R9 missed", 64'(stat_missed), 0);

    // Random phases alternating push bias and pop bias.
    for (int ph = 0; ph < 12; ph++) begin
      for (int i = 0; i < 2000; i++) begin
        logic [3:0] t;
        bit p, c;
        t = ($urandom() % 3 == 0) ? 4'($urandom()) : 4'h0;
        p = (ph % 2) ? ($urandom() % 2 == 0) : ($urandom() % 10 == 0);
        c = ($urandom() % 400 == 0);
        cyc(t, p, c);
      end
    end
    idle(4);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule